// File: doc/BRIEF.md
# Breakpoint Acknowledge Sequencer

This block works beside a simple in-order instruction sequencer and handles hardware breakpoint requests. A request does not interrupt anything when it arrives. It is held as a pending flag. An instruction breakpoint becomes pending only when the sequencer reports that the tagged instruction has executed. The pending breakpoint is serviced at an instruction boundary or when exception processing finishes. At that point the controller records the current PC, the next PC and the status word. It waits for the shared bus to go idle and then runs one acknowledge read in address space 0 at address 0x1E.

The way that read ends decides the outcome. A normal termination tells the sequencer to continue, as if the breakpoint had never occurred. A bus-error termination asks for exception processing. In that case the block supplies vector 12, byte offset 0x30, the recorded frame values and a supervisor-stack select. The read data is discarded in both cases. A request that arrives while the acknowledge is in flight is kept and serviced at the next eligible point.

The controller has five states, with these transitions:
- IDLE → WAIT when the flag is pending and a boundary or exception-done strobe is seen.
- WAIT → ACK when the bus is idle.
- ACK → RESUME on a normal termination.
- ACK → EXCEPT on an error termination.
- RESUME → IDLE and EXCEPT → IDLE unconditionally.

Top module: `bkpt_ack_ctrl`

## Requirements
- R1: A request on `brk_req_i` sets the pending flag. On its own it produces no bus request, no `resume_o` and no `exc_req_o`.
- R2: A pulse on `ibrk_tag_i` arms an instruction breakpoint. It becomes pending only on an `insn_exec_i` pulse (in the same or a later cycle). Until then a boundary strobe starts no acknowledge.
- R3: Service starts only while the flag is pending and `boundary_i` or `exc_done_i` is high. Without a pending flag these strobes produce no bus activity.
- R4: The acknowledge read waits while `bus_busy_i` is high. It then drives `bus_req_o`=1, `bus_rd_o`=1, `bus_fc_o`=0 and `bus_addr_o`=0x1E, and holds all of them steady until `bus_ack_i` or `bus_err_i` arrives.
- R5: A normal termination (`bus_ack_i` without `bus_err_i`) gives a one-cycle `resume_o` pulse in the next cycle and clears the pending flag.
- R6: An error termination (`bus_err_i`, which wins over `bus_ack_i`) gives a one-cycle `exc_req_o` pulse in the next cycle, with `vec_num_o`=12 and `vec_off_o`=0x30. Outside that pulse both outputs are 0.
- R7: During `exc_req_o`, `stk_cur_pc_o`, `stk_next_pc_o` and `stk_sr_o` hold the values of `cur_pc_i`, `next_pc_i` and `sr_i` from the cycle in which service started, and `stk_super_o` is 1.
- R8: `bus_rdata_i` has no effect on any output.
- R9: A request arriving while the acknowledge is waiting or in flight stays pending and is serviced at the next eligible strobe.
- R10: Reset clears the pending flag, returns to IDLE and drives all pulses and `bus_req_o` low.
- R11: `vec_off_o` always equals `vec_num_o` times four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_req_i | input | 1 | Breakpoint request, pends at once |
| ibrk_tag_i | input | 1 | Instruction breakpoint tag, arms |
| insn_exec_i | input | 1 | Tagged instruction executed |
| boundary_i | input | 1 | Instruction boundary strobe |
| exc_done_i | input | 1 | Exception processing finished strobe |
| cur_pc_i | input | PC_W | PC of the current instruction |
| next_pc_i | input | PC_W | PC of the next instruction |
| sr_i | input | SR_W | Status register copy |
| bus_busy_i | input | 1 | Bus occupied by another master |
| bus_req_o | output | 1 | Acknowledge cycle active |
| bus_rd_o | output | 1 | Read strobe |
| bus_fc_o | output | FC_W | Address-space code |
| bus_addr_o | output | ADDR_W | Cycle address |
| bus_ack_i | input | 1 | Normal termination |
| bus_err_i | input | 1 | Bus error termination |
| bus_rdata_i | input | DATA_W | Read data, discarded |
| resume_o | output | 1 | Continue with the next instruction |
| exc_req_o | output | 1 | Start exception processing |
| vec_num_o | output | VEC_W | Vector number |
| vec_off_o | output | VEC_W+2 | Vector byte offset |
| stk_cur_pc_o | output | PC_W | Frame: current PC |
| stk_next_pc_o | output | PC_W | Frame: next PC |
| stk_sr_o | output | SR_W | Frame: status copy |
| stk_super_o | output | 1 | Frame goes to supervisor stack |

## Verification
The bench targets the corner cases where a sloppy implementation would fail.
- A request arriving during the acknowledge: a design that cleared the pending flag at termination would silently drop it.
- An instruction tag without execution: a design that pended on the tag would acknowledge too early.
- A bus held busy, and a cycle that stays open for several clocks: a design that ignored arbitration would drive the bus early, and one that did not hold its outputs would let the address wander.
- Simultaneous ack and error terminations, frame values that change after service starts, and non-zero read data: these expose a wrong priority, a late capture, or data leaking into the outputs.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACK,
        ST_RESUME,
        ST_EXCEPT
    } bkpt_st_t;

    localparam int unsigned BKPT_VECTOR = 12;
    localparam int unsigned ACK_SPACE   = 0;
    localparam int unsigned ACK_ADDRESS = 32'h1E;

    function automatic int unsigned vec_to_offset(input int unsigned vec);
        return vec * 4;
    endfunction

endpackage

// File: rtl/bkpt_pend.sv
module bkpt_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_req_i,
    input  logic ibrk_tag_i,
    input  logic insn_exec_i,
    input  logic hold_i,
    input  logic clr_i,
    output logic pend_o
);

    logic armed_q;
    logic late_q;
    logic pend_q;
    logic set_w;

    // instruction breakpoint only pends once its instruction executes
    assign set_w = brk_req_i | (insn_exec_i & (armed_q | ibrk_tag_i));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (insn_exec_i) begin
            armed_q <= 1'b0;
        end else if (ibrk_tag_i) begin
            armed_q <= 1'b1;
        end
    end

    // late_q keeps requests that arrive while an acknowledge is in flight
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            late_q <= 1'b0;
        end else if (clr_i) begin
            pend_q <= set_w | late_q;
            late_q <= 1'b0;
        end else if (hold_i) begin
            late_q <= late_q | set_w;
        end else begin
            pend_q <= pend_q | set_w;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq
    import bkpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic boundary_i,
    input  logic exc_done_i,
    input  logic bus_busy_i,
    input  logic bus_ack_i,
    input  logic bus_err_i,
    output logic cap_o,
    output logic hold_o,
    output logic clr_o,
    output logic bus_req_o,
    output logic resume_o,
    output logic exc_o
);

    bkpt_st_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_i && (boundary_i || exc_done_i)) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!bus_busy_i) state_d = ST_ACK;
            end
            ST_ACK: begin
                if (bus_err_i)      state_d = ST_EXCEPT;
                else if (bus_ack_i) state_d = ST_RESUME;
            end
            ST_RESUME: state_d = ST_IDLE;
            ST_EXCEPT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cap_o     = 1'b0;
        hold_o    = 1'b0;
        clr_o     = 1'b0;
        bus_req_o = 1'b0;
        resume_o  = 1'b0;
        exc_o     = 1'b0;
        unique case (state_q)
            ST_IDLE:   cap_o = pend_i && (boundary_i || exc_done_i);
            ST_WAIT:   hold_o = 1'b1;
            ST_ACK: begin
                hold_o    = 1'b1;
                bus_req_o = 1'b1;
                clr_o     = bus_ack_i || bus_err_i;
            end
            ST_RESUME: resume_o = 1'b1;
            ST_EXCEPT: exc_o = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/bkpt_frame.sv
module bkpt_frame #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned SR_W  = 16,
    parameter int unsigned VEC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              exc_i,
    input  logic [PC_W-1:0]   cur_pc_i,
    input  logic [PC_W-1:0]   next_pc_i,
    input  logic [SR_W-1:0]   sr_i,
    output logic [PC_W-1:0]   stk_cur_pc_o,
    output logic [PC_W-1:0]   stk_next_pc_o,
    output logic [SR_W-1:0]   stk_sr_o,
    output logic              stk_super_o,
    output logic [VEC_W-1:0]  vec_num_o,
    output logic [VEC_W+1:0]  vec_off_o
);

    import bkpt_pkg::*;

    localparam int unsigned OFF_W = VEC_W + 2;
    localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(BKPT_VECTOR);
    localparam logic [OFF_W-1:0] OFF_VAL = OFF_W'(vec_to_offset(BKPT_VECTOR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_cur_pc_o  <= '0;
            stk_next_pc_o <= '0;
            stk_sr_o      <= '0;
        end else if (cap_i) begin
            stk_cur_pc_o  <= cur_pc_i;
            stk_next_pc_o <= next_pc_i;
            stk_sr_o      <= sr_i;
        end
    end

    assign stk_super_o = exc_i;
    assign vec_num_o   = exc_i ? VEC_VAL : '0;
    assign vec_off_o   = exc_i ? OFF_VAL : '0;

endmodule

// File: rtl/bkpt_ack_ctrl.sv
module bkpt_ack_ctrl #(
    parameter int unsigned PC_W   = 32,
    parameter int unsigned SR_W   = 16,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned FC_W   = 3,
    parameter int unsigned VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              brk_req_i,
    input  logic              ibrk_tag_i,
    input  logic              insn_exec_i,
    input  logic              boundary_i,
    input  logic              exc_done_i,
    input  logic [PC_W-1:0]   cur_pc_i,
    input  logic [PC_W-1:0]   next_pc_i,
    input  logic [SR_W-1:0]   sr_i,
    input  logic              bus_busy_i,
    output logic              bus_req_o,
    output logic              bus_rd_o,
    output logic [FC_W-1:0]   bus_fc_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    input  logic              bus_ack_i,
    input  logic              bus_err_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              resume_o,
    output logic              exc_req_o,
    output logic [VEC_W-1:0]  vec_num_o,
    output logic [VEC_W+1:0]  vec_off_o,
    output logic [PC_W-1:0]   stk_cur_pc_o,
    output logic [PC_W-1:0]   stk_next_pc_o,
    output logic [SR_W-1:0]   stk_sr_o,
    output logic              stk_super_o
);

    import bkpt_pkg::*;

    localparam logic [ADDR_W-1:0] ACK_ADDR_L = ADDR_W'(ACK_ADDRESS);
    localparam logic [FC_W-1:0]   ACK_FC_L   = FC_W'(ACK_SPACE);

    logic pend_w, cap_w, hold_w, clr_w, req_w, exc_w;
    logic rdata_unused_w;

    // acknowledge data is read and thrown away
    assign rdata_unused_w = ^bus_rdata_i;

    bkpt_pend u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .brk_req_i   (brk_req_i),
        .ibrk_tag_i  (ibrk_tag_i),
        .insn_exec_i (insn_exec_i),
        .hold_i      (hold_w),
        .clr_i       (clr_w),
        .pend_o      (pend_w)
    );

    bkpt_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend_w),
        .boundary_i (boundary_i),
        .exc_done_i (exc_done_i),
        .bus_busy_i (bus_busy_i),
        .bus_ack_i  (bus_ack_i),
        .bus_err_i  (bus_err_i),
        .cap_o      (cap_w),
        .hold_o     (hold_w),
        .clr_o      (clr_w),
        .bus_req_o  (req_w),
        .resume_o   (resume_o),
        .exc_o      (exc_w)
    );

    bkpt_frame #(.PC_W(PC_W), .SR_W(SR_W), .VEC_W(VEC_W)) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .cap_i         (cap_w),
        .exc_i         (exc_w),
        .cur_pc_i      (cur_pc_i),
        .next_pc_i     (next_pc_i),
        .sr_i          (sr_i),
        .stk_cur_pc_o  (stk_cur_pc_o),
        .stk_next_pc_o (stk_next_pc_o),
        .stk_sr_o      (stk_sr_o),
        .stk_super_o   (stk_super_o),
        .vec_num_o     (vec_num_o),
        .vec_off_o     (vec_off_o)
    );

    assign exc_req_o  = exc_w;
    assign bus_req_o  = req_w;
    assign bus_rd_o   = req_w;
    assign bus_fc_o   = req_w ? ACK_FC_L : '1;
    assign bus_addr_o = req_w ? ACK_ADDR_L : '0;

endmodule

// File: rtl/bkpt_ack_chk.sv
module bkpt_ack_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned FC_W   = 3,
    parameter int unsigned VEC_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_busy_i,
    input logic              bus_req_o,
    input logic              bus_rd_o,
    input logic [FC_W-1:0]   bus_fc_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic              bus_ack_i,
    input logic              bus_err_i,
    input logic              resume_o,
    input logic              exc_req_o,
    input logic [VEC_W-1:0]  vec_num_o,
    input logic [VEC_W+1:0]  vec_off_o,
    input logic              stk_super_o
);

    assert_ack_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> (bus_rd_o && bus_fc_o == '0 && bus_addr_o == ADDR_W'(32'h1E)));

    assert_ack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i && !bus_err_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_fc_o)));

    assert_ack_after_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req_o) |-> $past(!bus_busy_i));

    assert_outcome_after_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_o || exc_req_o) |-> $past(bus_req_o));

    assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(resume_o && exc_req_o));

    assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |-> (vec_num_o == VEC_W'(12) && stk_super_o));

    assert_offset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        vec_off_o == {vec_num_o, 2'b00});

endmodule

bind bkpt_ack_ctrl bkpt_ack_chk #(.ADDR_W(ADDR_W), .FC_W(FC_W), .VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_busy_i  (bus_busy_i),
    .bus_req_o   (bus_req_o),
    .bus_rd_o    (bus_rd_o),
    .bus_fc_o    (bus_fc_o),
    .bus_addr_o  (bus_addr_o),
    .bus_ack_i   (bus_ack_i),
    .bus_err_i   (bus_err_i),
    .resume_o    (resume_o),
    .exc_req_o   (exc_req_o),
    .vec_num_o   (vec_num_o),
    .vec_off_o   (vec_off_o),
    .stk_super_o (stk_super_o)
);

// File: tb/tb_bkpt_ack_ctrl.sv
`timescale 1ns/1ps
module tb_bkpt_ack_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        brk_req_i = 0, ibrk_tag_i = 0, insn_exec_i = 0;
    logic        boundary_i = 0, exc_done_i = 0;
    logic [31:0] cur_pc_i = 0, next_pc_i = 0;
    logic [15:0] sr_i = 0;
    logic        bus_busy_i = 0, bus_ack_i = 0, bus_err_i = 0;
    logic [15:0] bus_rdata_i = 0;
    logic        bus_req_o, bus_rd_o, resume_o, exc_req_o, stk_super_o;
    logic [2:0]  bus_fc_o;
    logic [31:0] bus_addr_o, stk_cur_pc_o, stk_next_pc_o;
    logic [15:0] stk_sr_o;
    logic [7:0]  vec_num_o;
    logic [9:0]  vec_off_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bkpt_ack_ctrl dut (
        .clk(clk), .rst_n(rst_n), .brk_req_i(brk_req_i), .ibrk_tag_i(ibrk_tag_i),
        .insn_exec_i(insn_exec_i), .boundary_i(boundary_i), .exc_done_i(exc_done_i),
        .cur_pc_i(cur_pc_i), .next_pc_i(next_pc_i), .sr_i(sr_i), .bus_busy_i(bus_busy_i),
        .bus_req_o(bus_req_o), .bus_rd_o(bus_rd_o), .bus_fc_o(bus_fc_o), .bus_addr_o(bus_addr_o),
        .bus_ack_i(bus_ack_i), .bus_err_i(bus_err_i), .bus_rdata_i(bus_rdata_i),
        .resume_o(resume_o), .exc_req_o(exc_req_o), .vec_num_o(vec_num_o), .vec_off_o(vec_off_o),
        .stk_cur_pc_o(stk_cur_pc_o), .stk_next_pc_o(stk_next_pc_o), .stk_sr_o(stk_sr_o),
        .stk_super_o(stk_super_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_brk();
        brk_req_i = 1; tick(1); brk_req_i = 0;
    endtask

    task automatic strobe_boundary();
        boundary_i = 1; tick(1); boundary_i = 0;
    endtask

    task automatic wait_req(output bit seen);
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            if (bus_req_o) begin seen = 1; break; end
            tick(1);
        end
    endtask

    // no outcome and no bus activity for n cycles
    task automatic quiet(input int n, input string req);
        bit bad = 0;
        for (int i = 0; i < n; i++) begin
            if (bus_req_o || resume_o || exc_req_o) bad = 1;
            tick(1);
        end
        chk(!bad, req, "unexpected activity", 64'(bad), 0);
    endtask

    task automatic terminate(input bit ack, input bit err, input logic [15:0] data);
        bus_ack_i = ack; bus_err_i = err; bus_rdata_i = data;
        tick(1);
        bus_ack_i = 0; bus_err_i = 0; bus_rdata_i = 0;
    endtask

    task automatic t_reset();
        chk(!bus_req_o && !resume_o && !exc_req_o, "R10", "outputs after reset",
            {bus_req_o, resume_o, exc_req_o}, 0);
        chk(vec_num_o == 0 && vec_off_o == 0, "R10", "vector after reset", {vec_num_o, vec_off_o}, 0);
        strobe_boundary();
        quiet(5, "R10");
    endtask

    task automatic t_normal();
        bit seen;
        pulse_brk();
        quiet(5, "R1");
        strobe_boundary();
        wait_req(seen);
        chk(seen, "R3", "ack on boundary", 64'(seen), 1);
        chk(bus_fc_o == 0 && bus_addr_o == 32'h1E && bus_rd_o, "R4", "ack target",
            {bus_fc_o, bus_addr_o}, 32'h1E);
        tick(2);
        chk(bus_req_o && bus_addr_o == 32'h1E, "R4", "ack held", 64'(bus_req_o), 1);
        terminate(1, 0, 16'hFFFF);
        chk(resume_o && !exc_req_o, "R5", "resume pulse", {resume_o, exc_req_o}, 2);
        chk(vec_num_o == 0 && vec_off_o == 0, "R8", "no vector from data", {vec_num_o, vec_off_o}, 0);
        tick(1);
        chk(!resume_o, "R5", "resume one cycle", 64'(resume_o), 0);
        strobe_boundary();
        quiet(5, "R5");
    endtask

    task automatic t_inst_bkpt();
        bit seen;
        ibrk_tag_i = 1; tick(1); ibrk_tag_i = 0;
        strobe_boundary();
        quiet(4, "R2");
        insn_exec_i = 1; tick(1); insn_exec_i = 0;
        exc_done_i = 1; tick(1); exc_done_i = 0;
        wait_req(seen);
        chk(seen, "R2", "ack after execution", 64'(seen), 1);
        terminate(1, 0, 0);
        chk(resume_o, "R3", "resume after exc_done service", 64'(resume_o), 1);
        tick(1);
    endtask

    task automatic t_error();
        bit seen;
        pulse_brk();
        bus_busy_i = 1;
        cur_pc_i = 32'h0000_1234; next_pc_i = 32'h0000_1238; sr_i = 16'h2704;
        strobe_boundary();
        cur_pc_i = 32'hDEAD_0000; next_pc_i = 32'hBEEF_0000; sr_i = 16'h0000;
        quiet(4, "R4");
        bus_busy_i = 0;
        wait_req(seen);
        chk(seen, "R4", "ack after bus idle", 64'(seen), 1);
        terminate(0, 1, 16'h5A5A);
        chk(exc_req_o && !resume_o, "R6", "exception pulse", {exc_req_o, resume_o}, 2);
        chk(vec_num_o == 12, "R6", "vector number", 64'(vec_num_o), 12);
        chk(vec_off_o == 10'h30, "R11", "vector offset", 64'(vec_off_o), 64'h30);
        chk(stk_cur_pc_o == 32'h1234, "R7", "frame current pc", stk_cur_pc_o, 32'h1234);
        chk(stk_next_pc_o == 32'h1238, "R7", "frame next pc", stk_next_pc_o, 32'h1238);
        chk(stk_sr_o == 16'h2704 && stk_super_o, "R7", "frame sr/super", {stk_super_o, stk_sr_o}, 17'h12704);
        tick(1);
        chk(!exc_req_o && vec_num_o == 0, "R6", "exception one cycle", {exc_req_o, vec_num_o}, 0);
    endtask

    task automatic t_both_term();
        bit seen;
        pulse_brk();
        strobe_boundary();
        wait_req(seen);
        terminate(1, 1, 0);
        chk(exc_req_o && !resume_o, "R6", "error wins over ack", {exc_req_o, resume_o}, 2);
        tick(1);
    endtask

    task automatic t_late();
        bit seen;
        pulse_brk();
        strobe_boundary();
        wait_req(seen);
        pulse_brk();
        terminate(1, 0, 0);
        chk(resume_o, "R9", "first service resumes", 64'(resume_o), 1);
        tick(1);
        strobe_boundary();
        wait_req(seen);
        chk(seen, "R9", "late request serviced", 64'(seen), 1);
        terminate(1, 0, 0);
        tick(1);
        strobe_boundary();
        quiet(4, "R9");
    endtask

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        t_reset();
        t_normal();
        t_inst_bkpt();
        t_error();
        t_both_term();
        t_late();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule